// File: doc/BRIEF.md
# Quasi-Bidirectional Parallel Port

This block is a byte-wide general-purpose I/O port modelled at the logic level. Each bit has a storage latch and a pad. A latch value of 0 makes the pad pull the pin low. A latch value of 1 releases the pin so that it can serve as an input. The CPU side writes the latch as a whole byte, or changes it in place with a read-modify-write operation. That operation always starts from the latch, never from the pin. Two read strobes return either the resolved pin levels or the latch contents.

A static mode input selects the pad flavour. With `od_mode` low, a released bit turns on a weak internal pull-up. With `od_mode` high, a released bit is open-drain: it has no pull-up and floats unless something outside pulls it. While `alt_en` is high, an external-memory address byte on `alt_addr` takes over the pads. The latch keeps accepting writes during that time, and its value returns to the pads when the override drops.

Latch updates are chosen by a three-way selector: UPD_HOLD (no request), UPD_WRITE (`wr_en`) and UPD_RMW (`rmw_en`). The read register has its own selector: SRC_HOLD (no strobe), SRC_PIN (`rd_pin`) and SRC_LATCH (`rd_latch`). Each selector is re-evaluated on every clock.

Top module: `qbd_port`

## Requirements
- R1: While `rst_n` is low and on release, every latch bit is 1, `rdata` is 0, `pad_drive_low` is all 0, and `pad_pullup_en` is all 1 when `od_mode` is 0.
- R2: A `wr_en` strobe loads `wr_data` into the latch at that clock edge. From then on, `pad_drive_low[i]` is the inverse of latch bit i when `alt_en` is 0.
- R3: With `od_mode` 0, a bit whose driven value is 1 has `pad_pullup_en` set and `pad_drive_low` clear.
- R4: With `od_mode` 1, `pad_pullup_en` is all 0. A released bit then shows only what the outside applies, and floats (X) if nothing is applied.
- R5: A `rd_pin` strobe captures `pad_in` as it stands before that edge, and presents it on `rdata` after the edge.
- R6: A `rd_latch` strobe presents the latch contents on `rdata` after the edge. The value captured is the one before any write or read-modify-write in the same cycle.
- R7: When `rd_pin` and `rd_latch` are both high, the pin wins. With neither strobe high, `rdata` holds its value.
- R8: An `rmw_en` strobe replaces the latch with latch OP `rmw_arg`, where `rmw_op` 00=AND, 01=OR, 10=XOR, 11=clear (latch AND NOT arg). The pin levels play no part.
- R9: When `wr_en` and `rmw_en` are both high, the plain write wins and the RMW is dropped.
- R10: While `alt_en` is 1, the pads follow `alt_addr` (drive low where the address bit is 0; pull-up by mode) and latch writes still take effect. After `alt_en` falls, the pads show the latch again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| od_mode | input | 1 | 1 = open-drain bits with no pull-up |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | WIDTH | Byte to store in the latch |
| rmw_en | input | 1 | Read-modify-write strobe |
| rmw_op | input | 2 | RMW operation code |
| rmw_arg | input | WIDTH | RMW operand |
| rd_pin | input | 1 | Read the resolved pins |
| rd_latch | input | 1 | Read the latch |
| rdata | output | WIDTH | Registered read data |
| alt_en | input | 1 | Address override active |
| alt_addr | input | WIDTH | Address byte for the override |
| pad_drive_low | output | WIDTH | Per-bit pull-down enable |
| pad_pullup_en | output | WIDTH | Per-bit weak pull-up enable |
| pad_in | input | WIDTH | Resolved pin levels |

## Verification
Two collisions matter most. A latch write or RMW can land in the same cycle as a latch read. A write can also land in the same cycle as an RMW, or while the address override holds the pads. The bench raises these strobes together on purpose, and also lets random traffic raise them. Its behavioural model takes the read from the pre-edge latch, lets the write win over the RMW, and keeps the latch updating under the override. It compares the pads and `rdata` against the design on every clock, using the case-equality operator so that floating open-drain bits are judged as X.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
    typedef enum logic [1:0] {
        RMW_AND = 2'b00,
        RMW_OR  = 2'b01,
        RMW_XOR = 2'b10,
        RMW_CLR = 2'b11
    } rmw_op_e;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_WRITE,
        UPD_RMW
    } upd_sel_e;

    typedef enum logic [1:0] {
        SRC_HOLD,
        SRC_PIN,
        SRC_LATCH
    } rd_src_e;
endpackage

// File: rtl/qbd_latch.sv
module qbd_latch
    import qbd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [WIDTH-1:0] rmw_arg,
    output logic [WIDTH-1:0] latch_q
);
    upd_sel_e         sel;
    logic [WIDTH-1:0] rmw_res;
    logic [WIDTH-1:0] latch_d;

    always_comb begin
        unique case (rmw_op_e'(rmw_op))
            RMW_AND: rmw_res = latch_q & rmw_arg;
            RMW_OR:  rmw_res = latch_q | rmw_arg;
            RMW_XOR: rmw_res = latch_q ^ rmw_arg;
            RMW_CLR: rmw_res = latch_q & ~rmw_arg;
            default: rmw_res = latch_q;
        endcase
    end

    always_comb begin
        if (wr_en)       sel = UPD_WRITE;
        else if (rmw_en) sel = UPD_RMW;
        else             sel = UPD_HOLD;
    end

    always_comb begin
        unique case (sel)
            UPD_WRITE: latch_d = wr_data;
            UPD_RMW:   latch_d = rmw_res;
            default:   latch_d = latch_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '1;
        else        latch_q <= latch_d;
    end

    // R1
    reset_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> latch_q == '1);
    // R2
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> latch_q == $past(wr_data));
    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rmw_en) |=> latch_q == $past(wr_data));
    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rmw_en) |=> $stable(latch_q));
endmodule

// File: rtl/qbd_pad_ctl.sv
module qbd_pad_ctl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic             alt_en,
    input  logic [WIDTH-1:0] alt_addr,
    input  logic             od_mode,
    output logic [WIDTH-1:0] drive_low,
    output logic [WIDTH-1:0] pullup_en
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic out_val;
        assign out_val      = alt_en ? alt_addr[i] : latch_q[i];
        assign drive_low[i] = ~out_val;
        assign pullup_en[i] = out_val & ~od_mode;
    end
endmodule

// File: rtl/qbd_read.sv
module qbd_read
    import qbd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_pin,
    input  logic             rd_latch,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] rdata_q
);
    rd_src_e src;

    always_comb begin
        if (rd_pin)        src = SRC_PIN;
        else if (rd_latch) src = SRC_LATCH;
        else               src = SRC_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (src)
                SRC_PIN:   rdata_q <= pad_in;
                SRC_LATCH: rdata_q <= latch_q;
                default:   rdata_q <= rdata_q;
            endcase
        end
    end

    // R6
    read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latch && !rd_pin) |=> rdata_q == $past(latch_q));
    // R7
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pin && !rd_latch) |=> $stable(rdata_q));
endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             od_mode,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rmw_en,
    input  logic [1:0]       rmw_op,
    input  logic [WIDTH-1:0] rmw_arg,
    input  logic             rd_pin,
    input  logic             rd_latch,
    output logic [WIDTH-1:0] rdata,
    input  logic             alt_en,
    input  logic [WIDTH-1:0] alt_addr,
    output logic [WIDTH-1:0] pad_drive_low,
    output logic [WIDTH-1:0] pad_pullup_en,
    input  logic [WIDTH-1:0] pad_in
);
    logic [WIDTH-1:0] latch_q;

    qbd_latch #(.WIDTH(WIDTH)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_arg(rmw_arg),
        .latch_q(latch_q)
    );

    qbd_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .latch_q(latch_q), .alt_en(alt_en), .alt_addr(alt_addr),
        .od_mode(od_mode), .drive_low(pad_drive_low),
        .pullup_en(pad_pullup_en)
    );

    qbd_read #(.WIDTH(WIDTH)) u_read (
        .clk(clk), .rst_n(rst_n), .rd_pin(rd_pin), .rd_latch(rd_latch),
        .pad_in(pad_in), .latch_q(latch_q), .rdata_q(rdata)
    );

    // R3
    pad_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_drive_low & pad_pullup_en) == '0);
    // R4
    od_no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        od_mode |-> pad_pullup_en == '0);
    // R10
    alt_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_en |-> pad_drive_low == ~alt_addr);
    // R2
    pad_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !alt_en) |=> (alt_en || pad_drive_low == ~$past(wr_data)));
endmodule

// File: tb/sim_qbd_port.sv
`timescale 1ns/1ps
module sim_qbd_port;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         od_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rmw_en = 1'b0;
    logic [1:0]   rmw_op = 2'b00;
    logic [W-1:0] rmw_arg = '0;
    logic         rd_pin = 1'b0;
    logic         rd_latch = 1'b0;
    logic [W-1:0] rdata;
    logic         alt_en = 1'b0;
    logic [W-1:0] alt_addr = '0;
    logic [W-1:0] pad_drive_low;
    logic [W-1:0] pad_pullup_en;
    logic [W-1:0] pad_in;
    logic [W-1:0] ext_en = '0;
    logic [W-1:0] ext_val = '0;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_latch;
    logic [W-1:0] m_rdata;

    always #4 clk = ~clk;

    function automatic logic [W-1:0] resolve(input logic [W-1:0] dl,
                                             input logic [W-1:0] pu,
                                             input logic [W-1:0] een,
                                             input logic [W-1:0] eval);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (dl[i])       r[i] = 1'b0;
            else if (pu[i])  r[i] = 1'b1;
            else if (een[i]) r[i] = eval[i];
            else             r[i] = 1'bx;
        end
        return r;
    endfunction

    assign pad_in = resolve(pad_drive_low, pad_pullup_en, ext_en, ext_val);

    qbd_port #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .od_mode(od_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rmw_en(rmw_en), .rmw_op(rmw_op),
        .rmw_arg(rmw_arg), .rd_pin(rd_pin), .rd_latch(rd_latch),
        .rdata(rdata), .alt_en(alt_en), .alt_addr(alt_addr),
        .pad_drive_low(pad_drive_low), .pad_pullup_en(pad_pullup_en),
        .pad_in(pad_in)
    );

    function automatic logic [W-1:0] m_out();
        return alt_en ? alt_addr : m_latch;
    endfunction
    function automatic logic [W-1:0] m_dl();
        return ~m_out();
    endfunction
    function automatic logic [W-1:0] m_pu();
        return od_mode ? '0 : m_out();
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "pad_drive_low", pad_drive_low, m_dl());
        check(tag, "pad_pullup_en", pad_pullup_en, m_pu());
        check(tag, "rdata", rdata, m_rdata);
    endtask

    task automatic tick(input string tag);
        logic [W-1:0] pin_pre;
        logic [W-1:0] nl;
        pin_pre = resolve(m_dl(), m_pu(), ext_en, ext_val);
        @(posedge clk);
        if (rd_pin)        m_rdata = pin_pre;
        else if (rd_latch) m_rdata = m_latch;
        nl = m_latch;
        if (wr_en) nl = wr_data;
        else if (rmw_en) begin
            case (rmw_op)
                2'b00: nl = m_latch & rmw_arg;
                2'b01: nl = m_latch | rmw_arg;
                2'b10: nl = m_latch ^ rmw_arg;
                default: nl = m_latch & ~rmw_arg;
            endcase
        end
        m_latch = nl;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        wr_en = 0; rmw_en = 0; rd_pin = 0; rd_latch = 0;
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_latch = '1;
        m_rdata = '0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        tick("R1");

        // R3: released bits pulled up, pin reads 1
        rd_pin = 1; tick("R3"); idle(); tick("R3");

        // R2: byte write
        wr_en = 1; wr_data = 8'hA5; tick("R2"); idle(); tick("R2");
        // R6: read latch
        rd_latch = 1; tick("R6"); idle(); tick("R6");
        // R5: read pin with pull-ups
        rd_pin = 1; tick("R5"); idle(); tick("R5");

        // R4: open-drain, partial external pull, floating bits read X
        od_mode = 1; ext_en = 8'hF0; ext_val = 8'h30;
        tick("R4");
        rd_pin = 1; tick("R4"); idle(); tick("R4");
        // R8: RMW uses latch though pin 7 reads low
        rmw_en = 1; rmw_op = 2'b01; rmw_arg = 8'h00; tick("R8");
        idle(); rd_latch = 1; tick("R8"); idle();
        rmw_en = 1; rmw_op = 2'b00; rmw_arg = 8'h3C; tick("R8");
        rmw_op = 2'b10; rmw_arg = 8'hFF; tick("R8");
        rmw_op = 2'b11; rmw_arg = 8'h81; tick("R8");
        idle(); rd_latch = 1; tick("R8"); idle();
        ext_en = 8'hFF; ext_val = 8'h5A;

        // R9: write and RMW together
        wr_en = 1; wr_data = 8'h0F; rmw_en = 1; rmw_op = 2'b01; rmw_arg = 8'hF0;
        tick("R9"); idle(); rd_latch = 1; tick("R9"); idle();
        // R6: write and latch read together return old latch
        wr_en = 1; wr_data = 8'hC3; rd_latch = 1; tick("R6"); idle(); tick("R6");
        // R7: both read strobes, pin wins; then hold
        rd_pin = 1; rd_latch = 1; tick("R7"); idle(); tick("R7"); tick("R7");

        // R10: override, writes continue underneath, release restores
        od_mode = 0; alt_en = 1; alt_addr = 8'h12; tick("R10");
        wr_en = 1; wr_data = 8'h99; tick("R10"); idle();
        alt_addr = 8'h34; rd_pin = 1; tick("R10"); idle();
        rd_latch = 1; tick("R10"); idle();
        alt_en = 0; tick("R10");

        // mixed traffic, every requirement
        for (int n = 0; n < 400; n++) begin
            wr_en = ($urandom % 4) == 0;
            wr_data = W'($urandom);
            rmw_en = ($urandom % 3) == 0;
            rmw_op = 2'($urandom);
            rmw_arg = W'($urandom);
            rd_pin = ($urandom % 3) == 0;
            rd_latch = ($urandom % 3) == 0;
            alt_en = ($urandom % 5) == 0;
            alt_addr = W'($urandom);
            od_mode = ($urandom % 4) == 0;
            ext_en = 8'hFF; ext_val = W'($urandom);
            tick("R2 R5 R6 R7 R8 R9 R10");
        end
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule